// File: doc/BRIEF.md
# Serial Fast-Command Decoder

The block samples a one-bit synchronous control line on every rising clock edge and decodes the short serial commands sent on it. Each recognised command becomes a one-cycle pulse: trigger accept, bunch-counter zero, resynchronisation, power-up reset, or a switch into calibration mode. The block also keeps the local bunch-crossing counter and the operating-mode register, and both follow those pulses. The line rests at 0. A 1 seen while the decoder is idle is the start bit of a command. The two bits after the start bit select the command.

The resynchronisation code `110` is also the first part of the two power-up reset codes, `110110` and `1100110`. For this reason the decoder does not act on `110` at once. It watches the following bits and decides only when the pattern is complete. If a bit arrives that no valid code allows, the decoder drops the partial command, sets a sticky error flag, and goes back to idle.

Top module: `fast_cmd_decoder`

## Requirements
- R1: The bit sequence 1,0,0 (first bit first) gives `l1a_o` high for exactly one cycle. The pulse comes in the cycle after the clock edge that sampled the last bit.
- R2: The sequence 1,0,1 gives a one-cycle `bc0_o` pulse, with the same timing as R1. `bx_cnt_o` reads 0 in the cycle after that pulse.
- R3: The sequence 1,1,0 followed by two 0 bits gives a one-cycle `resync_o` pulse after the fifth bit. `bx_cnt_o` reads 0 in the cycle after that pulse.
- R4: The sequences 1,1,0,1,1,0 and 1,1,0,0,1,1,0 each give a one-cycle `pwrup_o` pulse after their last bit and no `resync_o` pulse. In the cycle after the pulse, `bx_cnt_o` is 0, `mode_o` is the default value (0), and `err_o` is 0.
- R5: The sequence 1,1,1 gives a one-cycle `calib_o` pulse. From the cycle after that pulse, `mode_o` holds the calibration value (1) until a power-up reset or a hard reset.
- R6: When no clear is pending, `bx_cnt_o` advances by one every cycle and wraps from ORBIT_LEN-1 (default 3563) to 0.
- R7: A bit that no valid code allows after the prefix 1,1,0 discards the command without any pulse and sets `err_o`. The flag stays set until a power-up reset or a hard reset.
- R8: At most one of the five command pulses is high in any cycle.
- R9: While `rst_n` is low at a clock edge, all pulses, `err_o`, `bx_cnt_o` and `mode_o` are 0. A command that was partly received when reset came is forgotten.
- R10: A line held at 0 gives no pulse. Commands may follow one another with no idle bit between them, and each one is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the line is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low hard reset |
| fc_line | input | 1 | Serial command line, idle level 0 |
| l1a_o | output | 1 | Trigger-accept pulse |
| bc0_o | output | 1 | Bunch-counter-zero pulse |
| resync_o | output | 1 | Resynchronisation pulse |
| pwrup_o | output | 1 | Power-up reset pulse |
| calib_o | output | 1 | Calibration-mode switch pulse |
| err_o | output | 1 | Sticky malformed-command flag |
| bx_cnt_o | output | BX_W | Local bunch-crossing counter |
| mode_o | output | MODE_W | Current operating mode |

## Verification
The hardest behaviour to reach is the branching that follows the shared `110` prefix. There, a resync, either power-up reset, or an error depends on one or two late bits. The stimulus drives every way out of that prefix: both full power-up tails, the plain resync, and a wrong bit at each tail position. It also sends commands back to back with no gap and drops reset in the middle of a command. Counter wrap-around needs a long quiet stretch with no clear, so the bench idles for more than a full orbit.

// File: rtl/fcd_pkg.sv
// Shared types for the serial fast-command decoder.
// Assumes: one command decision at most per clock edge.
package fcd_pkg;

    // Position inside a command, including the power-up tails after 1,1,0
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_LO,
        ST_HI,
        ST_TAIL,
        ST_SA1,
        ST_SA2,
        ST_LA0,
        ST_LA1,
        ST_LA2
    } fcd_state_e;

    // Outcome decided at one clock edge
    typedef enum logic [2:0] {
        EV_NONE,
        EV_L1A,
        EV_BC0,
        EV_RESYNC,
        EV_PWRUP,
        EV_CALIB,
        EV_BAD
    } fcd_event_e;

    // Registered one-cycle command pulses
    typedef struct packed {
        logic l1a;
        logic bc0;
        logic resync;
        logic pwrup;
        logic calib;
    } fcd_pulse_t;

endpackage

// File: rtl/fcd_seq_fsm.sv
// Pattern recogniser for the serial command line.
// Walks one state per sampled bit. The decision is made at the edge that
// samples the last bit of a pattern and appears as a registered pulse in
// the following cycle. After 1,1,0 it follows both power-up tails and
// the plain resync tail (two zeros); any other bit there is malformed.
// Assumes: rst_n is synchronous and active low.
module fcd_seq_fsm
    import fcd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output fcd_pulse_t pulse_o,
    output logic       err_o
);

    fcd_state_e state_q;
    fcd_state_e state_d;
    fcd_event_e event_d;
    fcd_pulse_t pulse_d;
    fcd_pulse_t pulse_q;
    logic       err_q;

    // Next state and decision from the current state and the sampled bit
    always_comb begin
        state_d = state_q;
        event_d = EV_NONE;
        case (state_q)
            ST_IDLE:  if (line_i) state_d = ST_START;
            ST_START: state_d = line_i ? ST_HI : ST_LO;
            ST_LO: begin
                state_d = ST_IDLE;
                event_d = line_i ? EV_BC0 : EV_L1A;
            end
            ST_HI: begin
                if (line_i) begin
                    state_d = ST_IDLE;
                    event_d = EV_CALIB;
                end else begin
                    state_d = ST_TAIL;
                end
            end
            ST_TAIL:  state_d = line_i ? ST_SA1 : ST_LA0;
            ST_SA1: begin
                if (line_i) begin
                    state_d = ST_SA2;
                end else begin
                    state_d = ST_IDLE;
                    event_d = EV_BAD;
                end
            end
            ST_SA2: begin
                state_d = ST_IDLE;
                event_d = line_i ? EV_BAD : EV_PWRUP;
            end
            ST_LA0: begin
                if (line_i) begin
                    state_d = ST_LA1;
                end else begin
                    state_d = ST_IDLE;
                    event_d = EV_RESYNC;
                end
            end
            ST_LA1: begin
                if (line_i) begin
                    state_d = ST_LA2;
                end else begin
                    state_d = ST_IDLE;
                    event_d = EV_BAD;
                end
            end
            ST_LA2: begin
                state_d = ST_IDLE;
                event_d = line_i ? EV_BAD : EV_PWRUP;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // Map the decision onto a single pulse line
    always_comb begin
        pulse_d = '0;
        case (event_d)
            EV_L1A:    pulse_d.l1a    = 1'b1;
            EV_BC0:    pulse_d.bc0    = 1'b1;
            EV_RESYNC: pulse_d.resync = 1'b1;
            EV_PWRUP:  pulse_d.pwrup  = 1'b1;
            EV_CALIB:  pulse_d.calib  = 1'b1;
            default:   pulse_d        = '0;
        endcase
    end

    // State, pulse and sticky error registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pulse_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
            if (event_d == EV_BAD) begin
                err_q <= 1'b1;
            end else if (pulse_q.pwrup) begin
                err_q <= 1'b0;
            end
        end
    end

    assign pulse_o = pulse_q;
    assign err_o   = err_q;

endmodule

// File: rtl/fcd_bx_counter.sv
// Local bunch-crossing counter.
// Counts 0..ORBIT_LEN-1 and wraps. It is cleared at the edge after any
// clearing pulse (bunch-counter zero, resync or power-up reset).
// Assumes: ORBIT_LEN <= 2**BX_W.
module fcd_bx_counter #(
    parameter int BX_W      = 12,
    parameter int ORBIT_LEN = 3564
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    output logic [BX_W-1:0] cnt_o
);

    localparam logic [BX_W-1:0] LAST = BX_W'(ORBIT_LEN - 1);

    logic [BX_W-1:0] cnt_q;

    // Advance, wrap at the orbit end, or clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/fcd_mode_reg.sv
// Operating-mode register.
// Holds MODE_DEFAULT after reset or a power-up reset pulse, and takes
// MODE_CALIB at the edge after a calibration pulse.
// Assumes: the two pulses are never high together.
module fcd_mode_reg #(
    parameter int MODE_W       = 2,
    parameter int MODE_DEFAULT = 0,
    parameter int MODE_CALIB   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrup_i,
    input  logic              calib_i,
    output logic [MODE_W-1:0] mode_o
);

    localparam logic [MODE_W-1:0] DEF_VAL = MODE_W'(MODE_DEFAULT);
    localparam logic [MODE_W-1:0] CAL_VAL = MODE_W'(MODE_CALIB);

    logic [MODE_W-1:0] mode_q;

    // Load the default or the calibration mode value
    always_ff @(posedge clk) begin
        if (!rst_n || pwrup_i) begin
            mode_q <= DEF_VAL;
        end else if (calib_i) begin
            mode_q <= CAL_VAL;
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/fast_cmd_decoder.sv
// Top of the serial fast-command decoder.
// Joins the pattern recogniser, the bunch-crossing counter and the mode
// register. Every output is registered.
// Assumes: fc_line is synchronous to clk.
module fast_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int BX_W         = 12,
    parameter int ORBIT_LEN    = 3564,
    parameter int MODE_W       = 2,
    parameter int MODE_DEFAULT = 0,
    parameter int MODE_CALIB   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fc_line,
    output logic              l1a_o,
    output logic              bc0_o,
    output logic              resync_o,
    output logic              pwrup_o,
    output logic              calib_o,
    output logic              err_o,
    output logic [BX_W-1:0]   bx_cnt_o,
    output logic [MODE_W-1:0] mode_o
);

    fcd_pulse_t pulse;
    logic       bx_clr;

    fcd_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (fc_line),
        .pulse_o (pulse),
        .err_o   (err_o)
    );

    assign bx_clr = pulse.bc0 | pulse.resync | pulse.pwrup;

    fcd_bx_counter #(
        .BX_W      (BX_W),
        .ORBIT_LEN (ORBIT_LEN)
    ) u_bx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (bx_clr),
        .cnt_o (bx_cnt_o)
    );

    fcd_mode_reg #(
        .MODE_W       (MODE_W),
        .MODE_DEFAULT (MODE_DEFAULT),
        .MODE_CALIB   (MODE_CALIB)
    ) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrup_i (pulse.pwrup),
        .calib_i (pulse.calib),
        .mode_o  (mode_o)
    );

    assign l1a_o    = pulse.l1a;
    assign bc0_o    = pulse.bc0;
    assign resync_o = pulse.resync;
    assign pwrup_o  = pulse.pwrup;
    assign calib_o  = pulse.calib;

endmodule

// File: rtl/fcd_checker.sv
// Temporal checks on the fast-command decoder ports, bound to the top.
module fcd_checker #(
    parameter int BX_W         = 12,
    parameter int ORBIT_LEN    = 3564,
    parameter int MODE_W       = 2,
    parameter int MODE_DEFAULT = 0,
    parameter int MODE_CALIB   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fc_line,
    input logic              l1a,
    input logic              bc0,
    input logic              resync,
    input logic              pwrup,
    input logic              calib,
    input logic              err,
    input logic [BX_W-1:0]   bx_cnt,
    input logic [MODE_W-1:0] mode
);

    localparam logic [BX_W-1:0]   LAST    = BX_W'(ORBIT_LEN - 1);
    localparam logic [MODE_W-1:0] DEF_VAL = MODE_W'(MODE_DEFAULT);
    localparam logic [MODE_W-1:0] CAL_VAL = MODE_W'(MODE_CALIB);

    logic clr;
    assign clr = bc0 | resync | pwrup;

    assert_l1a_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
        l1a |-> (!$past(fc_line) && !$past(fc_line, 2) && $past(fc_line, 3)));

    assert_l1a_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        l1a |=> !l1a);

    assert_bc0_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bc0 |=> (bx_cnt == '0));

    assert_resync_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> (!$past(fc_line) && !$past(fc_line, 2)));

    assert_resync_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (bx_cnt == '0));

    assert_pwrup_defaults_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwrup |=> (bx_cnt == '0 && mode == DEF_VAL && !err));

    assert_pwrup_last_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwrup |-> !$past(fc_line));

    assert_calib_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        calib |=> (mode == CAL_VAL));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && bx_cnt != LAST) |=> (bx_cnt == $past(bx_cnt) + 1'b1));

    assert_count_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_cnt == LAST) |=> (bx_cnt == '0));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !pwrup) |=> err);

    assert_pulse_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({l1a, bc0, resync, pwrup, calib}));

endmodule

bind fast_cmd_decoder fcd_checker #(
    .BX_W         (BX_W),
    .ORBIT_LEN    (ORBIT_LEN),
    .MODE_W       (MODE_W),
    .MODE_DEFAULT (MODE_DEFAULT),
    .MODE_CALIB   (MODE_CALIB)
) u_fcd_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .fc_line (fc_line),
    .l1a     (l1a_o),
    .bc0     (bc0_o),
    .resync  (resync_o),
    .pwrup   (pwrup_o),
    .calib   (calib_o),
    .err     (err_o),
    .bx_cnt  (bx_cnt_o),
    .mode    (mode_o)
);

// File: tb/test_fast_cmd_decoder.sv
// Bench for the fast-command decoder: a string-matching reference model
// runs beside the design and is compared at every falling edge.
module test_fast_cmd_decoder;

    localparam int BX_W   = 12;
    localparam int ORBIT  = 3564;
    localparam int MODE_W = 2;

    logic              clk   = 1'b0;
    logic              rst_n = 1'b0;
    logic              line  = 1'b0;
    logic              l1a_o, bc0_o, resync_o, pwrup_o, calib_o, err_o;
    logic [BX_W-1:0]   bx_cnt_o;
    logic [MODE_W-1:0] mode_o;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    fast_cmd_decoder i_fast_cmd_decoder (
        .clk      (clk),
        .rst_n    (rst_n),
        .fc_line  (line),
        .l1a_o    (l1a_o),
        .bc0_o    (bc0_o),
        .resync_o (resync_o),
        .pwrup_o  (pwrup_o),
        .calib_o  (calib_o),
        .err_o    (err_o),
        .bx_cnt_o (bx_cnt_o),
        .mode_o   (mode_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic bit is_prefix(string s, string p);
        if (s.len() > p.len()) return 1'b0;
        return p.substr(0, s.len() - 1) == s;
    endfunction

    // 0 incomplete, 1 l1a, 2 bc0, 3 resync, 4 pwrup, 5 calib, 6 malformed
    function automatic int classify(string s);
        if (s == "100") return 1;
        if (s == "101") return 2;
        if (s == "11000") return 3;
        if (s == "110110" || s == "1100110") return 4;
        if (s == "111") return 5;
        if (is_prefix(s, "100") || is_prefix(s, "101") || is_prefix(s, "111") ||
            is_prefix(s, "11000") || is_prefix(s, "110110") ||
            is_prefix(s, "1100110")) return 0;
        return 6;
    endfunction

    string q = "";
    bit    go = 1'b0;
    bit    e_l1a, e_bc0, e_res, e_pwr, e_cal, e_err;
    int    e_cnt = 0;
    int    e_mode = 0;

    always @(posedge clk) begin
        int k;
        go = 1'b1;
        if (!rst_n) begin
            q = "";
            {e_l1a, e_bc0, e_res, e_pwr, e_cal, e_err} = '0;
            e_cnt = 0;
            e_mode = 0;
        end else begin
            if (e_bc0 || e_res || e_pwr) e_cnt = 0;
            else if (e_cnt == ORBIT - 1) e_cnt = 0;
            else e_cnt = e_cnt + 1;
            if (e_pwr) e_mode = 0;
            else if (e_cal) e_mode = 1;
            if (e_pwr) e_err = 1'b0;
            {e_l1a, e_bc0, e_res, e_pwr, e_cal} = '0;
            if (q.len() > 0 || line) begin
                q = {q, line ? "1" : "0"};
                k = classify(q);
                if (k != 0) q = "";
                case (k)
                    1: e_l1a = 1'b1;
                    2: e_bc0 = 1'b1;
                    3: e_res = 1'b1;
                    4: e_pwr = 1'b1;
                    5: e_cal = 1'b1;
                    6: e_err = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    int seen_l1a = 0, seen_bc0 = 0, seen_res = 0, seen_pwr = 0, seen_cal = 0;
    int multi = 0, wraps = 0, prev_cnt = 0;

    always @(negedge clk) begin
        if (go) begin
            chk(l1a_o === e_l1a, "R1", "l1a_o", int'(l1a_o), int'(e_l1a));
            chk(bc0_o === e_bc0, "R2", "bc0_o", int'(bc0_o), int'(e_bc0));
            chk(resync_o === e_res, "R3", "resync_o", int'(resync_o), int'(e_res));
            chk(pwrup_o === e_pwr, "R4", "pwrup_o", int'(pwrup_o), int'(e_pwr));
            chk(calib_o === e_cal, "R5", "calib_o", int'(calib_o), int'(e_cal));
            chk(mode_o === MODE_W'(e_mode), "R5", "mode_o", int'(mode_o), e_mode);
            chk(bx_cnt_o === BX_W'(e_cnt), "R6", "bx_cnt_o", int'(bx_cnt_o), e_cnt);
            chk(err_o === e_err, "R7", "err_o", int'(err_o), int'(e_err));
            seen_l1a += int'(l1a_o);
            seen_bc0 += int'(bc0_o);
            seen_res += int'(resync_o);
            seen_pwr += int'(pwrup_o);
            seen_cal += int'(calib_o);
            if ($countones({l1a_o, bc0_o, resync_o, pwrup_o, calib_o}) > 1) multi++;
            if (rst_n && prev_cnt == ORBIT - 1 && bx_cnt_o == '0) wraps++;
            prev_cnt = int'(bx_cnt_o);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send(input string s);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            line = (s[i] == 8'h31);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line = 1'b0;
        end
    endtask

    function automatic int pulses_total();
        return seen_l1a + seen_bc0 + seen_res + seen_pwr + seen_cal;
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R9: state held in reset
        chk(bx_cnt_o == '0 && mode_o == '0 && !err_o, "R9", "reset state",
            int'(bx_cnt_o) + int'(mode_o) + int'(err_o), 0);
        chk(pulses_total() == 0, "R9", "pulses in reset", pulses_total(), 0);
        rst_n = 1'b1;

        idle(20);
        chk(pulses_total() == 0, "R10", "idle line pulses", pulses_total(), 0);

        send("100"); idle(2);
        send("100101"); idle(3);
        chk(seen_l1a == 2, "R1", "l1a count", seen_l1a, 2);
        chk(seen_bc0 == 1, "R2", "bc0 count", seen_bc0, 1);

        send("111"); idle(2);
        chk(mode_o == 2'd1, "R5", "mode after calib", int'(mode_o), 1);

        send("11000"); idle(2);
        chk(seen_res == 1, "R3", "resync count", seen_res, 1);

        send("110110"); idle(2);
        chk(seen_pwr == 1 && mode_o == '0, "R4", "short power-up", seen_pwr, 1);
        chk(seen_res == 1, "R4", "no resync on power-up", seen_res, 1);
        send("1100110"); idle(2);
        chk(seen_pwr == 2, "R4", "long power-up", seen_pwr, 2);

        base = pulses_total();
        send("11010"); idle(2);
        chk(err_o == 1'b1, "R7", "err after bad tail", int'(err_o), 1);
        send("110111"); idle(1);
        send("110010"); idle(1);
        send("1100111"); idle(2);
        chk(pulses_total() == base, "R7", "no pulse from malformed", pulses_total(), base);
        chk(err_o == 1'b1, "R7", "err stays set", int'(err_o), 1);

        send("110110"); idle(2);
        chk(err_o == 1'b0, "R4", "power-up clears err", int'(err_o), 0);

        send("111100"); idle(2);
        chk(seen_l1a == 3 && seen_cal == 2, "R10", "back-to-back commands",
            seen_l1a * 10 + seen_cal, 32);

        base = pulses_total();
        send("11");
        @(negedge clk); line = 1'b0; rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(6);
        chk(pulses_total() == base, "R9", "partial command dropped by reset",
            pulses_total(), base);

        idle(ORBIT + 20);
        chk(wraps >= 1, "R6", "orbit wrap seen", wraps, 1);
        chk(multi == 0, "R8", "cycles with two pulses", multi, 0);

        finish_run();
    end

endmodule